// File: doc/BRIEF.md
# Snoop Unit Register Block

This block is the software-visible register file of the snoop control unit in a small multicore cluster. It sits on a simple request bus that carries a byte offset into a 256-byte window, a write enable, an access size in bytes, and write data. A read returns its data one clock after the request. The coherency machinery is outside this block. What is here is the register state that software uses to set up and watch that machinery.

Two pieces of state are stored: a one-bit enable held in the control register, and a 32-bit word of per-core power state. The power word can be reached at any of four consecutive byte offsets. A read at one of these offsets returns the word shifted down to that byte. A write at one of them replaces only the byte lanes selected by the access size, starting at that byte. A read-only configuration word reports the number of cores, taken from a parameter. The cache-invalidate, address-filter and access-control locations, and every other offset, read as zero and discard writes.

Top module: `snoop_regblk`

## Requirements
- R1: After reset the control bit and the power word are zero, and `rd_data` is zero until the first read.
- R2: A write of a legal size to offset 0x00 stores only `wr_data[0]`. A read of 0x00 returns that bit in bit 0, with bits 31:1 at zero.
- R3: Offset 0x04 reads as ((2^N − 1) << 4) | (N − 1), where N is `NUM_CORES`. Writes to 0x04 change nothing.
- R4: A read at offset 0x08+k (k = 0..3) returns the power word logically shifted right by 8·k bits.
- R5: A write at 0x08+k of size S bytes replaces bytes k to k+S−1 of the power word with `wr_data` bytes 0 to S−1. All other bytes keep their value.
- R6: Lanes that a write at 0x08+k would place above bit 31 are dropped. For example, a 4-byte write at 0x0B changes only bits 31:24.
- R7: A write whose `size` field is not 1, 2 or 4 changes neither the control bit nor the power word.
- R8: Offsets 0x0C, 0x40, 0x44, 0x50, 0x54 and every other unmapped offset read as zero, and writes to them change no state.
- R9: `rd_data` is updated on the clock edge that samples a read request. It holds its value while no read is requested, including during writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Bus request valid |
| wr_en | input | 1 | 1 = write, 0 = read (qualified by `req`) |
| offset | input | 8 | Byte offset in the 256-byte window |
| size | input | 3 | Access size in bytes; 1, 2 and 4 are legal |
| wr_data | input | 32 | Write data, right-aligned |
| rd_data | output | 32 | Registered read data |

## Verification
The bench builds two copies of the block on one shared bus: one with `NUM_CORES` = 4 and one with the default of 1. This lets the configuration word be checked at its full four-bit mask (0xF3) and at its minimum (0x10). The four-core copy is used for the random stimulus. Random traffic mixes all eight `size` codes, so illegal sizes and byte or halfword writes reach every power-word lane, including those that spill past bit 31.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  // Byte-lane mask for a given access size; zero for illegal sizes.
  function automatic logic [DATA_W-1:0] size_mask(input logic [2:0] sz);
    case (sz)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      3'd4:    return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  // Read-only configuration word: N ones from bit 4 up, N-1 in low bits.
  function automatic logic [DATA_W-1:0] cfg_word(input int n);
    return (((32'(1) << n) - 32'd1) << 4) | 32'(n - 1);
  endfunction
endpackage

// File: rtl/snoop_decode.sv
module snoop_decode
  import snoop_pkg::*;
(
  input  logic [ADDR_W-1:0] offset,
  output logic              hit_ctrl,
  output logic              hit_cfg,
  output logic              hit_pwr,
  output logic [1:0]        lane
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 8'h04;
  localparam logic [ADDR_W-3:0] PWR_WORD = 6'h02;

  always_comb begin
    hit_ctrl = (offset == OFF_CTRL);
    hit_cfg  = (offset == OFF_CFG);
    hit_pwr  = (offset[ADDR_W-1:2] == PWR_WORD);
    lane     = offset[1:0];
  end
endmodule

// File: rtl/snoop_pwr_word.sv
module snoop_pwr_word
  import snoop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        lane,
  input  logic [2:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word_q
);
  logic [4:0]        shamt;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] lane_data;
  logic              upd;

  always_comb begin
    shamt     = {lane, 3'b000};
    lane_mask = size_mask(size) << shamt;
    lane_data = (wdata & size_mask(size)) << shamt;
    upd       = we && size_legal(size);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word_q <= '0;
    else if (upd) word_q <= (word_q & ~lane_mask) | (lane_data & lane_mask);
  end

  // R5: a single-byte write leaves the bytes below its lane untouched
  p_low_bytes_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && size == 3'd1 && lane == 2'd3) |=> $stable(word_q[23:0]));

  // R6: any write at the top lane only touches bits 31:24
  p_top_lane_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lane == 2'd3) |=> $stable(word_q[23:0]));

  // R7: illegal sizes never alter the word
  p_bad_size_pwr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !size_legal(size)) |=> $stable(word_q));
endmodule

// File: rtl/snoop_regblk.sv
module snoop_regblk
  import snoop_pkg::*;
#(
  parameter int NUM_CORES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr_en,
  input  logic [7:0]        offset,
  input  logic [2:0]        size,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data
);
  localparam int               LANES   = DATA_W / 8;
  localparam logic [DATA_W-1:0] CFG_VAL = cfg_word(NUM_CORES);

  logic              hit_ctrl, hit_cfg, hit_pwr;
  logic [1:0]        lane;
  logic              wr_fire, rd_fire, ctrl_we, pwr_we;
  logic              ctrl_q;
  logic [DATA_W-1:0] pwr_q;
  logic [DATA_W-1:0] pwr_view [LANES];
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rd_q;

  snoop_decode u_dec (
    .offset   (offset),
    .hit_ctrl (hit_ctrl),
    .hit_cfg  (hit_cfg),
    .hit_pwr  (hit_pwr),
    .lane     (lane)
  );

  always_comb begin
    wr_fire = req && wr_en;
    rd_fire = req && !wr_en;
    ctrl_we = wr_fire && hit_ctrl && size_legal(size);
    pwr_we  = wr_fire && hit_pwr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= 1'b0;
    else if (ctrl_we) ctrl_q <= wr_data[0];
  end

  snoop_pwr_word u_pwr (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (pwr_we),
    .lane   (lane),
    .size   (size),
    .wdata  (wr_data),
    .word_q (pwr_q)
  );

  // One right-shifted view of the power word per byte offset.
  for (genvar k = 0; k < LANES; k++) begin : g_view
    assign pwr_view[k] = pwr_q >> (8 * k);
  end

  always_comb begin
    rd_val = '0;
    if (hit_ctrl)     rd_val = {{(DATA_W-1){1'b0}}, ctrl_q};
    else if (hit_cfg) rd_val = CFG_VAL;
    else if (hit_pwr) rd_val = pwr_view[lane];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_fire) rd_q <= rd_val;
  end

  assign rd_data = rd_q;

  // R2: control reads never show upper bits
  p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && offset == 8'h00) |=> (rd_data[31:1] == '0));

  // R7: illegal-size writes leave the control bit alone
  p_bad_size_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !size_legal(size)) |=> $stable(ctrl_q));

  // R8: writes outside the two writable locations change no state
  p_unmapped_wi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && offset != 8'h00 && offset[7:2] != 6'h02)
      |=> ($stable(ctrl_q) && $stable(pwr_q)));

  // R9: read data holds when no read is requested
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_data));
endmodule

// File: tb/snoop_regblk_tb.sv
module snoop_regblk_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  offset = '0;
  logic [2:0]  size = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, rd_data_one;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic        m_ctrl = 1'b0;
  logic [31:0] m_pwr = '0;

  always #2 clk = ~clk;

  snoop_regblk #(.NUM_CORES(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en), .offset(offset),
    .size(size), .wr_data(wr_data), .rd_data(rd_data));

  snoop_regblk u_dut_one (
    .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en), .offset(offset),
    .size(size), .wr_data(wr_data), .rd_data(rd_data_one));

  function automatic bit legal(input logic [2:0] s);
    return s == 3'd1 || s == 3'd2 || s == 3'd4;
  endfunction

  // Expected read value, built byte by byte.
  function automatic logic [31:0] exp_read(input logic [7:0] off, input int n);
    logic [31:0] r = '0;
    if (off == 8'h00) r = {31'b0, m_ctrl};
    else if (off == 8'h04) begin
      for (int i = 0; i < n; i++) r[4+i] = 1'b1;
      r[3:0] = 4'(n - 1);
    end else if (off >= 8'h08 && off <= 8'h0B) begin
      for (int b = 0; b < 4; b++)
        if (b + int'(off - 8'h08) < 4) r[8*b +: 8] = m_pwr[8*(b + int'(off - 8'h08)) +: 8];
    end
    return r;
  endfunction

  function automatic void model_write(input logic [7:0] off, input logic [2:0] s,
                                      input logic [31:0] d);
    int nb = int'(s);
    int k  = int'(off) - 8;
    if (!legal(s)) return;
    if (off == 8'h00) m_ctrl = d[0];
    else if (off >= 8'h08 && off <= 8'h0B)
      for (int b = 0; b < 4; b++)
        if (b >= k && b - k < nb) m_pwr[8*b +: 8] = d[8*(b-k) +: 8];
  endfunction

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] off, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    req = 1; wr_en = 1; offset = off; size = s; wr_data = d;
    @(negedge clk);
    req = 0; wr_en = 0;
    model_write(off, s, d);
  endtask

  task automatic do_read(input string rq, input logic [7:0] off);
    @(negedge clk);
    req = 1; wr_en = 0; offset = off; size = 3'($urandom % 8);
    @(negedge clk);
    req = 0;
    chk(rq, rd_data, exp_read(off, 4));
    chk(rq, rd_data_one, exp_read(off, 1));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] pool [12] = '{8'h00, 8'h04, 8'h08, 8'h09, 8'h0A, 8'h0B,
                              8'h0C, 8'h40, 8'h44, 8'h50, 8'h54, 8'h01};
    logic [31:0] held;
    void'($urandom(32'h0005_EED1));
    repeat (3) @(negedge clk);
    chk("R1 rd_data after reset", rd_data, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd_data before read", rd_data, 32'h0);
    do_read("R1 control reset", 8'h00);
    do_read("R1 power reset", 8'h08);

    do_write(8'h00, 3'd4, 32'hFFFF_FFFF);
    do_read("R2 control bit0", 8'h00);
    do_write(8'h00, 3'd1, 32'h0000_00FE);
    do_read("R2 control even", 8'h00);
    do_write(8'h00, 3'd2, 32'h0000_0003);

    do_read("R3 config", 8'h04);
    do_write(8'h04, 3'd4, 32'h0);
    do_read("R3 config after write", 8'h04);

    do_write(8'h08, 3'd4, 32'h4433_2211);
    for (int k = 0; k < 4; k++) do_read("R4 shifted view", 8'(8 + k));

    do_write(8'h0A, 3'd1, 32'hFFFF_FFAA);
    do_read("R5 byte lane", 8'h08);
    do_write(8'h09, 3'd2, 32'hFFFF_BBCC);
    do_read("R5 halfword lane", 8'h08);

    do_write(8'h0B, 3'd4, 32'h1234_5678);
    do_read("R6 word at top lane", 8'h08);
    do_write(8'h0A, 3'd4, 32'hDEAD_BEEF);
    do_read("R6 word at lane2", 8'h08);

    do_write(8'h08, 3'd3, 32'h0);
    do_write(8'h08, 3'd0, 32'h0);
    do_write(8'h08, 3'd7, 32'h0);
    do_write(8'h00, 3'd3, 32'h0);
    do_read("R7 power after bad size", 8'h08);
    do_read("R7 control after bad size", 8'h00);

    foreach (pool[i]) if (i >= 6) begin
      do_write(pool[i], 3'd4, 32'hFFFF_FFFF);
      do_read("R8 raz location", pool[i]);
    end
    do_write(8'hF0, 3'd4, 32'hFFFF_FFFF);
    do_read("R8 unmapped", 8'hF0);
    do_read("R8 power untouched", 8'h08);
    do_read("R8 control untouched", 8'h00);

    do_read("R9 setup", 8'h04);
    held = rd_data;
    do_write(8'h00, 3'd1, 32'h0);
    repeat (3) @(negedge clk);
    chk("R9 hold through write and idle", rd_data, held);

    for (int n = 0; n < 400; n++) begin
      logic [7:0] off = ($urandom % 4 == 0) ? 8'($urandom) : pool[$urandom % 12];
      if ($urandom % 2) do_write(off, 3'($urandom % 8), $urandom);
      else do_read("R4 R5 R7 R8 random", off);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule